// File: doc/BRIEF.md
# Pipelined Rotor Substitution Cipher

This block is a byte-wide cipher datapath modelled on a rotor machine. A byte entering the block is substituted by five rotor stages in turn. It then goes through a reflector whose table also carries the plugboard swaps, and then back through five return stages that undo the rotor substitutions in reverse order. Every rotor has a forward table and its own copy of the inverse table. The return path therefore never shares a memory with the forward path, and the block takes a new byte on every clock with no stall.

Each stage adds a per-rotor offset that comes from an external stepping controller. The offsets are sampled together with the byte and move down the pipeline with it, so the forward and return stages of one rotor use the same offset for that byte. Tables are written through a load port while the pipeline is empty. A rotor write of entry `a = d` also writes the inverse entry `d = a`. A reflector write pairs `a` and `d` in both directions.

Because the reflector is an involution, the block is its own inverse. Feeding the ciphertext back with the same tables and offsets gives the plaintext back.

Top module: `rotor_cipher_pipe`

## Requirements
- R1: `outValid` repeats `inValid` exactly 13 clock edges later, one byte per clock, including back-to-back bytes and gaps. There is no backpressure.
- R2: For a byte x with rotor offsets o0..o4, the output is computed in three steps. Forward: x = F_i[(x + o_i) mod 256] for i = 0..4. Reflector: x = Rf[x]. Return: x = (I_i[x] - o_i) mod 256 for i = 4 down to 0. Here F is the forward table, I its inverse and Rf the reflector table.
- R3: `inOffsets` is sampled in the same cycle as its byte, with rotor i in bits [8i+7:8i]. Offsets that change on every cycle, including the extremes 0x00 and 0xFF, apply only to the byte they were sampled with.
- R4: Feeding a produced ciphertext back with the same offsets and tables reproduces the original plaintext.
- R5: With a permutation in every rotor and a fixed-point-free involution in the reflector, no output byte equals its own input byte.
- R6: A load with `loadSel` = r (0..4) writes forward entry F_r[loadAddr] = loadData and inverse entry I_r[loadData] = loadAddr. Reloading a rotor changes later results accordingly.
- R7: A load is ignored if `inValid` is high in the same cycle or if any byte is still in flight.
- R8: `loadSel` = 5 writes the reflector pair Rf[loadAddr] = loadData and Rf[loadData] = loadAddr. `loadSel` values 6 and 7 change no table.
- R9: While reset is asserted, `outValid` is low and `outData` is 0x00.
- R10: While `outValid` is low, `outData` keeps the last value it had.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Input byte is valid this cycle |
| inData | input | 8 | Input byte |
| inOffsets | input | 40 | Five 8-bit rotor offsets, rotor i in bits [8i+7:8i] |
| loadEn | input | 1 | Table write request |
| loadSel | input | 3 | Target table: 0..4 rotor, 5 reflector |
| loadAddr | input | 8 | Table entry index |
| loadData | input | 8 | Table entry value |
| outValid | output | 1 | Output byte is valid |
| outData | output | 8 | Output byte |

## Verification
The bench sends long random streams with bubbles and offsets that change every cycle. A design that shifted its offsets one stage out of step with the data, or that let a return stage use a different offset from its forward stage, would give wrong bytes and would fail the round-trip test.

It tries table writes while bytes are in flight and in the same cycle as `inValid`, and it writes to the unused table selects. It then sweeps all 256 input values with zero offsets. Any write that was wrongly accepted would corrupt the permutation and show up as a mismatch.

Offset and data values of 0x00 and 0xFF test that the modulo-256 arithmetic wraps correctly. Checks during the gaps catch an output that changes while `outValid` is low.

// File: rtl/rotor_cipher_pkg.sv
package rotor_cipher_pkg;
  localparam int SYM_W    = 8;
  localparam int ROT_N    = 5;
  localparam int TAB_N    = 1 << SYM_W;
  localparam int PIPE_N   = 2 * ROT_N + 3;   // in reg, rotors, reflector, return rotors, out reg
  localparam int OFF_W    = SYM_W * ROT_N;
  localparam int SEL_W    = $clog2(ROT_N + 1);
  localparam int REFL_SEL = ROT_N;

  typedef struct packed {
    logic [PIPE_N-1:0] adv;     // per-register advance strobes
    logic [ROT_N-1:0]  rotWe;   // rotor table write strobes
    logic              reflWe;  // reflector table write strobe
  } cipherStrobe_t;
endpackage

// File: rtl/rotor_cipher_rotor.sv
module rotor_cipher_rotor
  import rotor_cipher_pkg::*;
(
  input  logic             clk,
  input  logic             we,
  input  logic [SYM_W-1:0] wAddr,
  input  logic [SYM_W-1:0] wData,
  input  logic [SYM_W-1:0] fwdIdx,
  output logic [SYM_W-1:0] fwdSym,
  input  logic [SYM_W-1:0] invIdx,
  output logic [SYM_W-1:0] invSym
);
  logic [SYM_W-1:0] fwdMem [TAB_N];
  logic [SYM_W-1:0] invMem [TAB_N];

  // One write fills both directions, so the inverse copy always tracks the forward table.
  always_ff @(posedge clk) begin
    if (we) begin
      fwdMem[wAddr] <= wData;
      invMem[wData] <= wAddr;
    end
  end

  assign fwdSym = fwdMem[fwdIdx];
  assign invSym = invMem[invIdx];
endmodule

// File: rtl/rotor_cipher_refl.sv
module rotor_cipher_refl
  import rotor_cipher_pkg::*;
(
  input  logic             clk,
  input  logic             we,
  input  logic [SYM_W-1:0] wAddr,
  input  logic [SYM_W-1:0] wData,
  input  logic [SYM_W-1:0] rdIdx,
  output logic [SYM_W-1:0] rdSym
);
  logic [SYM_W-1:0] pairMem [TAB_N];

  // Each write sets a swap pair, which keeps the table an involution.
  always_ff @(posedge clk) begin
    if (we) begin
      pairMem[wAddr] <= wData;
      pairMem[wData] <= wAddr;
    end
  end

  assign rdSym = pairMem[rdIdx];
endmodule

// File: rtl/rotor_cipher_ctrl.sv
module rotor_cipher_ctrl
  import rotor_cipher_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic             loadEn,
  input  logic [SEL_W-1:0] loadSel,
  output cipherStrobe_t    strobe,
  output logic             outValid
);
  logic [PIPE_N-1:0] vPipe;
  logic              busy;
  logic              loadOk;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) vPipe <= '0;
    else       vPipe <= {vPipe[PIPE_N-2:0], inValid};
  end

  assign busy   = inValid | (|vPipe);
  assign loadOk = loadEn & ~busy;

  always_comb begin
    strobe.adv = {vPipe[PIPE_N-2:0], inValid};
    for (int r = 0; r < ROT_N; r++) begin
      strobe.rotWe[r] = loadOk && (loadSel == SEL_W'(r));
    end
    strobe.reflWe = loadOk && (loadSel == SEL_W'(REFL_SEL));
  end

  assign outValid = vPipe[PIPE_N-1];
endmodule

// File: rtl/rotor_cipher_dp.sv
module rotor_cipher_dp
  import rotor_cipher_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  cipherStrobe_t    strobe,
  input  logic [SYM_W-1:0] inData,
  input  logic [OFF_W-1:0] inOffsets,
  input  logic [SYM_W-1:0] loadAddr,
  input  logic [SYM_W-1:0] loadData,
  output logic [SYM_W-1:0] outData
);
  localparam int OFF_N = PIPE_N - 2;   // offsets are needed up to the last return stage

  logic [SYM_W-1:0] sym  [PIPE_N];
  logic [SYM_W-1:0] nxt  [PIPE_N];
  logic [OFF_W-1:0] offs [OFF_N];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int k = 0; k < PIPE_N; k++) sym[k]  <= '0;
      for (int k = 0; k < OFF_N; k++)  offs[k] <= '0;
    end else begin
      for (int k = 0; k < PIPE_N; k++) begin
        if (strobe.adv[k]) sym[k] <= nxt[k];
      end
      if (strobe.adv[0]) offs[0] <= inOffsets;
      for (int k = 1; k < OFF_N; k++) begin
        if (strobe.adv[k]) offs[k] <= offs[k-1];
      end
    end
  end

  assign nxt[0] = inData;

  for (genvar r = 0; r < ROT_N; r++) begin : g_rot
    localparam int RET_K = 2 * ROT_N - r;   // register feeding this rotor's return stage
    logic [SYM_W-1:0] fwdOff, retOff, fwdIdx, fwdSym, invSym;

    assign fwdOff = offs[r][r*SYM_W +: SYM_W];
    assign retOff = offs[RET_K][r*SYM_W +: SYM_W];
    assign fwdIdx = sym[r] + fwdOff;

    rotor_cipher_rotor i_rotor (
      .clk    (clk),
      .we     (strobe.rotWe[r]),
      .wAddr  (loadAddr),
      .wData  (loadData),
      .fwdIdx (fwdIdx),
      .fwdSym (fwdSym),
      .invIdx (sym[RET_K]),
      .invSym (invSym)
    );

    assign nxt[r+1]     = fwdSym;
    assign nxt[RET_K+1] = invSym - retOff;
  end

  logic [SYM_W-1:0] reflSym;

  rotor_cipher_refl i_refl (
    .clk   (clk),
    .we    (strobe.reflWe),
    .wAddr (loadAddr),
    .wData (loadData),
    .rdIdx (sym[ROT_N]),
    .rdSym (reflSym)
  );

  assign nxt[ROT_N+1]  = reflSym;
  assign nxt[PIPE_N-1] = sym[PIPE_N-2];
  assign outData       = sym[PIPE_N-1];
endmodule

// File: rtl/rotor_cipher_pipe.sv
module rotor_cipher_pipe
  import rotor_cipher_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic [SYM_W-1:0] inData,
  input  logic [OFF_W-1:0] inOffsets,
  input  logic             loadEn,
  input  logic [SEL_W-1:0] loadSel,
  input  logic [SYM_W-1:0] loadAddr,
  input  logic [SYM_W-1:0] loadData,
  output logic             outValid,
  output logic [SYM_W-1:0] outData
);
  cipherStrobe_t strobe;

  rotor_cipher_ctrl i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .loadEn   (loadEn),
    .loadSel  (loadSel),
    .strobe   (strobe),
    .outValid (outValid)
  );

  rotor_cipher_dp i_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .inData    (inData),
    .inOffsets (inOffsets),
    .loadAddr  (loadAddr),
    .loadData  (loadData),
    .outData   (outData)
  );
endmodule

// File: rtl/rotor_cipher_sva.sv
module rotor_cipher_sva
  import rotor_cipher_pkg::*;
(
  input logic             clk,
  input logic             rstN,
  input logic             inValid,
  input logic [SYM_W-1:0] inData,
  input logic             outValid,
  input logic [SYM_W-1:0] outData,
  input cipherStrobe_t    strobe
);
  // Shadow of the input side, kept independently of the control logic
  logic [PIPE_N-1:0] vSh;
  logic [SYM_W-1:0]  dSh [PIPE_N];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      vSh <= '0;
      for (int k = 0; k < PIPE_N; k++) dSh[k] <= '0;
    end else begin
      vSh    <= {vSh[PIPE_N-2:0], inValid};
      dSh[0] <= inData;
      for (int k = 1; k < PIPE_N; k++) dSh[k] <= dSh[k-1];
    end
  end

  AST_VALID_DELAY: assert property (@(posedge clk) disable iff (!rstN)
    outValid == vSh[PIPE_N-1]); // R1
  AST_NO_SELF_MAP: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> outData != dSh[PIPE_N-1]); // R5
  AST_LOAD_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    ((|strobe.rotWe) || strobe.reflWe) |-> (!inValid && vSh == '0)); // R7
  AST_ONE_TABLE_WE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.rotWe, strobe.reflWe})); // R8
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !outValid |-> $stable(outData)); // R10
endmodule

bind rotor_cipher_pipe rotor_cipher_sva i_sva (
  .clk      (clk),
  .rstN     (rstN),
  .inValid  (inValid),
  .inData   (inData),
  .outValid (outValid),
  .outData  (outData),
  .strobe   (strobe)
);

// File: tb/test_rotor_cipher_pipe.sv
module test_rotor_cipher_pipe;
  import rotor_cipher_pkg::*;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             inValid = 1'b0;
  logic [SYM_W-1:0] inData = '0;
  logic [OFF_W-1:0] inOffsets = '0;
  logic             loadEn = 1'b0;
  logic [SEL_W-1:0] loadSel = '0;
  logic [SYM_W-1:0] loadAddr = '0;
  logic [SYM_W-1:0] loadData = '0;
  logic             outValid;
  logic [SYM_W-1:0] outData;

  always #5 clk = ~clk;

  rotor_cipher_pipe i_rotor_cipher_pipe (.*);

  int nChk = 0;
  int nBad = 0;
  bit done = 1'b0;

  // Reference tables
  logic [7:0] mFwd  [ROT_N][TAB_N];
  logic [7:0] mInv  [ROT_N][TAB_N];
  logic [7:0] mRefl [TAB_N];

  // Expected-output history, one slot per pipeline register
  bit         hV   [PIPE_N];
  logic [7:0] hD   [PIPE_N];
  logic [7:0] hIn  [PIPE_N];
  string      hTag [PIPE_N];
  logic [7:0] lastOut;

  logic [7:0]       ptSave [64];
  logic [OFF_W-1:0] ofSave [64];
  logic [7:0]       ctSave [64];
  logic [7:0]       shuf   [TAB_N];

  function automatic logic [7:0] model(logic [7:0] x, logic [OFF_W-1:0] o);
    logic [7:0] y = x;
    for (int i = 0; i < ROT_N; i++) y = mFwd[i][8'(y + o[i*8 +: 8])];
    y = mRefl[y];
    for (int i = ROT_N - 1; i >= 0; i--) y = 8'(mInv[i][y] - o[i*8 +: 8]);
    return y;
  endfunction

  task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    nChk++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic shuffle();
    for (int i = 0; i < TAB_N; i++) shuf[i] = 8'(i);
    for (int i = TAB_N - 1; i > 0; i--) begin
      int j = $urandom_range(0, i);
      logic [7:0] t = shuf[i];
      shuf[i] = shuf[j];
      shuf[j] = t;
    end
  endtask

  // One clock: compare the output against the oldest history slot, then drive new inputs.
  task automatic step(bit v, logic [7:0] d, logic [OFF_W-1:0] o, bit le, logic [SEL_W-1:0] ls,
                      logic [7:0] la, logic [7:0] ld, string tag, logic [7:0] expD);
    @(negedge clk);
    if (hV[PIPE_N-1]) begin
      check(outValid == 1'b1, "R1 valid", 32'(outValid), 1);
      check(outData == hD[PIPE_N-1], hTag[PIPE_N-1], 32'(outData), 32'(hD[PIPE_N-1]));
      check(outData != hIn[PIPE_N-1], "R5 self map", 32'(outData), 32'(~hIn[PIPE_N-1]));
      lastOut = outData;
    end else begin
      check(outValid == 1'b0, "R1 idle", 32'(outValid), 0);
      check(outData == lastOut, "R10 hold", 32'(outData), 32'(lastOut));
    end
    for (int k = PIPE_N - 1; k > 0; k--) begin
      hV[k] = hV[k-1]; hD[k] = hD[k-1]; hIn[k] = hIn[k-1]; hTag[k] = hTag[k-1];
    end
    hV[0] = v; hD[0] = expD; hIn[0] = d; hTag[0] = tag;
    inValid = v; inData = d; inOffsets = o;
    loadEn = le; loadSel = ls; loadAddr = la; loadData = ld;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(0, 8'h00, '0, 0, '0, 8'h00, 8'h00, "", 8'h00);
  endtask

  task automatic send(logic [7:0] d, logic [OFF_W-1:0] o, string tag);
    step(1, d, o, 0, '0, 8'h00, 8'h00, tag, model(d, o));
  endtask

  task automatic loadRotor(int r);
    shuffle();
    for (int a = 0; a < TAB_N; a++) begin
      step(0, 8'h00, '0, 1, SEL_W'(r), 8'(a), shuf[a], "", 8'h00);
      mFwd[r][a] = shuf[a];
      mInv[r][shuf[a]] = 8'(a);
    end
  endtask

  task automatic loadRefl();
    shuffle();
    for (int i = 0; i < TAB_N / 2; i++) begin
      step(0, 8'h00, '0, 1, SEL_W'(REFL_SEL), shuf[2*i], shuf[2*i+1], "", 8'h00);
      mRefl[shuf[2*i]]   = shuf[2*i+1];
      mRefl[shuf[2*i+1]] = shuf[2*i];
    end
  endtask

  function automatic logic [OFF_W-1:0] randOff();
    return {$urandom, $urandom} & {OFF_W{1'b1}};
  endfunction

  task automatic finishRun();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  endtask

  initial begin
    void'($urandom(32'd4711));
    for (int k = 0; k < PIPE_N; k++) begin hV[k] = 0; hD[k] = '0; hIn[k] = '0; hTag[k] = ""; end
    lastOut = 8'h00;
    repeat (3) @(negedge clk);
    check(outValid == 1'b0, "R9 reset valid", 32'(outValid), 0);
    check(outData == 8'h00, "R9 reset data", 32'(outData), 0);
    rstN = 1'b1;

    // R6 R8: fill all tables
    for (int r = 0; r < ROT_N; r++) loadRotor(r);
    loadRefl();
    idle(2);

    // R2 R3: random stream, random bubbles, offsets changing every cycle
    for (int i = 0; i < 300; i++) begin
      if ($urandom_range(0, 3) != 0) send(8'($urandom), randOff(), "R2 R3 stream");
      else idle(1);
    end

    // R3: wrap corners of data and offsets
    send(8'hFF, {OFF_W{1'b1}}, "R3 all ff");
    send(8'h00, {OFF_W{1'b1}}, "R3 data 00 off ff");
    send(8'hFF, '0, "R3 data ff off 00");
    send(8'h00, '0, "R3 all 00");
    send(8'h80, 40'h01_FF_00_FF_01, "R3 mixed");
    idle(PIPE_N);

    // R4: round trip through the block
    for (int i = 0; i < 64; i++) begin
      ptSave[i] = 8'($urandom);
      ofSave[i] = randOff();
      ctSave[i] = model(ptSave[i], ofSave[i]);
      send(ptSave[i], ofSave[i], "R2 pre round trip");
    end
    for (int i = 0; i < 64; i++)
      step(1, ctSave[i], ofSave[i], 0, '0, 8'h00, 8'h00, "R4 round trip", ptSave[i]);
    idle(PIPE_N);

    // R7: loads attempted while busy or alongside inValid must be dropped
    for (int i = 0; i < 20; i++)
      step(1, 8'(i), '0, 1, '0, 8'(i), ~mFwd[0][i], "R7 stream with load", model(8'(i), '0));
    for (int i = 0; i < PIPE_N - 1; i++)
      step(0, 8'h00, '0, 1, SEL_W'(i % ROT_N), 8'(i), 8'(i + 1), "", 8'h00);
    idle(1);
    // R8: unused selects while idle
    step(0, 8'h00, '0, 1, SEL_W'(6), 8'h10, 8'h11, "", 8'h00);
    step(0, 8'h00, '0, 1, SEL_W'(7), 8'h22, 8'h23, "", 8'h00);
    idle(1);
    for (int x = 0; x < TAB_N; x++) send(8'(x), '0, "R7 R8 sweep after dropped loads");
    idle(PIPE_N);

    // R6 R8: reload one rotor and the reflector, results must follow the new tables
    loadRotor(2);
    loadRefl();
    idle(1);
    for (int i = 0; i < 100; i++) send(8'($urandom), randOff(), "R6 R8 after reload");
    idle(PIPE_N + 2);

    done = 1'b1;
    finishRun();
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nBad++;
      $display("FAIL R1 watchdog: actual timeout expected completion");
      finishRun();
    end
  end
endmodule